// File: doc/BRIEF.md
# Servo reference toggle generator

This block produces the square-wave reference that the drum and capstan phase loops of a tape transport compare against. A programmable half-period value sets the time between output edges. A down-counter reloads from that value every time the output changes, so the output has a 50% duty cycle. In playback the counter runs freely. As an option, each period can instead start from a pulse on an external trigger input.

In record, every period starts from a vertical-sync pulse. That pulse flips the output and restarts the counter. The counter then makes the mid-period edge. If the next sync pulse never arrives, the counter also makes a fill-in edge in its place. Two masks protect the loop from noisy sync, and each has its own start rule. The toggle mask stops sync pulses from flipping the output. The reload mask stops them from restarting the counter. After a fill-in edge the reload mask waits through a short gap before it starts. A late but genuine pulse in that gap can still realign the counter without making an extra edge.

Sync locking is chosen in one of two ways: automatically from a noise flag, or by a manual override. An optional frame mode lets an accepted sync pulse force the output level from the parity of the detected field.

Top module: `ref_toggle_gen`

## Requirements
- R1: With half-period H, a free-running output changes level every H clock cycles. The high and low times are therefore equal.
- R2: In playback (`rec_mode`=0, `ext_sel`=0) pulses on `vsync_in` have no effect on the output or on the counter.
- R3: In playback with `ext_sel`=1, each `ext_trig` pulse flips the output and restarts the count. One more edge follows H cycles later, and then the output holds until the next trigger.
- R4: In record with sync locking active, an accepted `vsync_in` pulse flips the output on the clock edge that samples it and restarts the count. The mid-period edge comes H cycles later.
- R5: In locked record, when no sync pulse arrives, the counter makes a fill-in edge 2H cycles after the start of the period.
- R6: A rising edge on `rec_mode` drives the output low on the next clock edge. It also restarts the count and clears both masks.
- R7: An accepted sync pulse opens both masks for floor(3H/2) cycles. A sync pulse k cycles later, with k ≤ floor(3H/2), changes neither the output nor the count. At k = floor(3H/2)+1 the pulse is accepted.
- R8: After a fill-in edge, a sync pulse within the first floor(H/2) cycles restarts the count without an edge. It also restarts both masks, measured from that pulse.
- R9: After a fill-in edge, a sync pulse that comes after the gap but while the mask is still open has no effect.
- R10: Sync locking applies in record when `auto_sel`=1 and `noise_in`=0, or when `auto_sel`=0 and `force_free`=0. In every other record case the output runs freely and sync is ignored.
- R11: With `frame_en`=1, an accepted sync pulse drives the output high when `field_in` equals `field_sel`, and low otherwise.
- R12: A sync pulse on the same cycle as the fill-in expiry gives a single edge. That edge counts as an accepted pulse, so no gap follows.
- R13: A new `half_period` value takes effect at the next counter reload. The interval already in progress is not changed.
- R14: Reset clears the output to low and clears the counter and both masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | HW | Half of the reference period, in clock cycles |
| rec_mode | input | 1 | 1 = record, 0 = playback |
| ext_sel | input | 1 | In playback, take each period start from `ext_trig` |
| auto_sel | input | 1 | 1 = locking follows `noise_in`, 0 = locking follows `force_free` |
| force_free | input | 1 | Manual override: free-run in record |
| frame_en | input | 1 | Accepted sync pulses force the output level from field parity |
| field_sel | input | 1 | Field parity that maps to a high output |
| field_in | input | 1 | Detected field parity |
| noise_in | input | 1 | Sync-noise flag from the detector |
| vsync_in | input | 1 | Vertical-sync pulse, one cycle wide |
| ext_trig | input | 1 | External trigger pulse, one cycle wide |
| ref_out | output | 1 | Reference square wave |

## Verification
Two functions can land in the same cycle: a sync pulse and the fill-in expiry of the counter. The bench lets the mask from the previous fill-in run out, then places a sync pulse exactly 2H cycles after it. It checks that exactly one edge appears. It then sends a second pulse five cycles later, a point that would fall inside the reload gap if the edge had been taken as a fill-in. That pulse must be rejected outright: the next edge must come at the mid-period point set by the coincident pulse, not five cycles after it.

// File: rtl/ref_toggle_gen.sv
module ref_toggle_gen #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_period,
  input  logic          rec_mode,
  input  logic          ext_sel,
  input  logic          auto_sel,
  input  logic          force_free,
  input  logic          frame_en,
  input  logic          field_sel,
  input  logic          field_in,
  input  logic          noise_in,
  input  logic          vsync_in,
  input  logic          ext_trig,
  output logic          ref_out
);
  localparam int MW = HW + 1;

  logic [HW-1:0] cnt;
  logic [MW-1:0] mask_t;
  logic [HW-1:0] gap_t;
  logic          mid;
  logic          rec_q;
  logic          locked;

  logic [HW+1:0] tri_hp;
  logic [MW-1:0] win_len;
  logic [HW-1:0] gap_len;
  logic [HW-1:0] reload;
  logic          rec_rise, ext_mode, expire, tmask, cmask, vs_hit, vs_flip, frame_lvl;

  assign tri_hp    = {2'b00, half_period} + {1'b0, half_period, 1'b0};
  assign win_len   = tri_hp[HW+1:1];
  assign gap_len   = half_period >> 1;
  assign reload    = half_period - 1'b1;
  assign rec_rise  = rec_mode & ~rec_q;
  assign locked    = rec_mode & (auto_sel ? ~noise_in : ~force_free);
  assign ext_mode  = ~rec_mode & ext_sel;
  assign expire    = (cnt == '0);
  assign tmask     = (mask_t != '0);
  assign cmask     = tmask & (gap_t == '0);
  assign vs_hit    = locked & vsync_in & ~cmask;
  assign vs_flip   = vs_hit & ~tmask;
  assign frame_lvl = ~(field_in ^ field_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      mask_t  <= '0;
      gap_t   <= '0;
      mid     <= 1'b0;
      rec_q   <= 1'b0;
      ref_out <= 1'b0;
    end else begin
      rec_q <= rec_mode;
      if (rec_rise) begin
        ref_out <= 1'b0;
        cnt     <= reload;
        mask_t  <= '0;
        gap_t   <= '0;
        mid     <= 1'b0;
      end else if (locked) begin
        mask_t <= tmask ? mask_t - 1'b1 : '0;
        gap_t  <= (gap_t != '0) ? gap_t - 1'b1 : '0;
        if (vs_hit) begin
          cnt    <= reload;
          mask_t <= win_len;
          gap_t  <= '0;
          if (vs_flip) begin
            ref_out <= frame_en ? frame_lvl : ~ref_out;
            mid     <= 1'b1;
          end
        end else if (expire) begin
          cnt     <= reload;
          ref_out <= ~ref_out;
          if (mid) begin
            mid <= 1'b0;
          end else begin
            mid    <= 1'b1;
            mask_t <= win_len;
            gap_t  <= gap_len;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (ext_mode) begin
        mask_t <= '0;
        gap_t  <= '0;
        if (ext_trig) begin
          cnt     <= reload;
          ref_out <= ~ref_out;
          mid     <= 1'b1;
        end else if (expire) begin
          if (mid) begin
            cnt     <= reload;
            ref_out <= ~ref_out;
            mid     <= 1'b0;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        mask_t <= '0;
        gap_t  <= '0;
        mid    <= 1'b0;
        if (expire) begin
          cnt     <= reload;
          ref_out <= ~ref_out;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ref_toggle_gen_chk.sv
module ref_toggle_gen_chk #(
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_mode,
  input logic          ext_sel,
  input logic          vsync_in,
  input logic          ext_trig,
  input logic [HW-1:0] half_period,
  input logic          ref_out,
  input logic [HW-1:0] cnt,
  input logic [HW:0]   mask_t,
  input logic [HW-1:0] gap_t,
  input logic          locked
);
  AST_PB_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_mode && !ext_sel && cnt != '0) |=> $stable(ref_out)); // R2

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_mode && ext_sel && !ext_trig && cnt != '0) |=> $stable(ref_out)); // R3

  AST_REC_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_mode) |=> !ref_out); // R6

  AST_MASK_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && mask_t != '0 && cnt != '0 && !$rose(rec_mode)) |=> $stable(ref_out)); // R7

  AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && vsync_in && mask_t != '0 && gap_t != '0 && !$rose(rec_mode))
      |=> (cnt == $past(half_period) - 1'b1)); // R8
endmodule

bind ref_toggle_gen ref_toggle_gen_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_mode(rec_mode), .ext_sel(ext_sel),
  .vsync_in(vsync_in), .ext_trig(ext_trig), .half_period(half_period),
  .ref_out(ref_out), .cnt(cnt), .mask_t(mask_t), .gap_t(gap_t), .locked(locked)
);

// File: tb/tb_ref_toggle_gen.sv
module tb_ref_toggle_gen;
  localparam int HW = 16;
  localparam int H  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] half_period = HW'(H);
  logic rec_mode = 0, ext_sel = 0, auto_sel = 0, force_free = 0, frame_en = 0;
  logic field_sel = 0, field_in = 0, noise_in = 0, vsync_in = 0, ext_trig = 0;
  logic ref_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ref_toggle_gen #(.HW(HW)) dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .rec_mode(rec_mode),
    .ext_sel(ext_sel), .auto_sel(auto_sel), .force_free(force_free),
    .frame_en(frame_en), .field_sel(field_sel), .field_in(field_in),
    .noise_in(noise_in), .vsync_in(vsync_in), .ext_trig(ext_trig), .ref_out(ref_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_toggle(output int n);
    logic old;
    old = ref_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (ref_out == old && n < 500);
  endtask

  task automatic vs_at(input int k);
    repeat (k - 1) @(negedge clk);
    vsync_in = 1'b1;
    @(negedge clk);
    vsync_in = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(ref_out == 1'b0, "R14", ref_out, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_free_run;
    int n;
    wait_toggle(n);
    wait_toggle(n); chk(n == H, "R1 first half", n, H);
    wait_toggle(n); chk(n == H, "R1 second half", n, H);
  endtask

  task automatic t_pb_sync;
    int n; logic old;
    wait_toggle(n);
    old = ref_out;
    vs_at(5);
    chk(ref_out == old, "R2 no edge", ref_out, old);
    wait_toggle(n); chk(n == H - 5, "R2 count kept", n, H - 5);
  endtask

  task automatic t_new_period;
    int n;
    wait_toggle(n);
    half_period = HW'(30);
    wait_toggle(n); chk(n == H, "R13 current interval", n, H);
    half_period = HW'(H);
    wait_toggle(n); chk(n == 30, "R13 next interval", n, 30);
    wait_toggle(n); chk(n == H, "R13 restored", n, H);
  endtask

  task automatic t_ext;
    int n, edges; logic old;
    ext_sel = 1'b1;
    @(negedge clk);
    old = ref_out;
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    chk(ref_out != old, "R3 trigger edge", ref_out, !old);
    wait_toggle(n); chk(n == H, "R3 mid edge", n, H);
    edges = 0;
    for (int i = 0; i < 3 * H; i++) begin
      old = ref_out;
      @(negedge clk);
      if (ref_out != old) edges++;
    end
    chk(edges == 0, "R3 hold", edges, 0);
    old = ref_out;
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    chk(ref_out != old, "R3 retrigger", ref_out, !old);
    ext_sel = 1'b0;
  endtask

  task automatic t_rec_entry;
    int n;
    do wait_toggle(n); while (ref_out != 1'b1);
    rec_mode = 1'b1;
    @(negedge clk);
    chk(ref_out == 1'b0, "R6 low on entry", ref_out, 0);
  endtask

  task automatic t_locked;
    int n; logic old;
    old = ref_out;
    vs_at(3);
    chk(ref_out != old, "R4 sync edge", ref_out, !old);
    wait_toggle(n); chk(n == H, "R4 mid edge", n, H);
    old = ref_out;
    vs_at(H);
    chk(ref_out != old, "R4 next sync edge", ref_out, !old);
    wait_toggle(n); chk(n == H, "R4 mid edge 2", n, H);
    wait_toggle(n); chk(n == H, "R5 fill-in", n, H);
    old = ref_out;
    vs_at(12);
    chk(ref_out == old, "R9 masked after gap", ref_out, old);
    wait_toggle(n); chk(n == H - 12, "R9 count kept", n, H - 12);
    wait_toggle(n); chk(n == H, "R5 second fill-in", n, H);
    old = ref_out;
    vs_at(5);
    chk(ref_out == old, "R8 no edge in gap", ref_out, old);
    wait_toggle(n); chk(n == H, "R8 realigned mid", n, H);
    old = ref_out;
    vs_at(10);
    chk(ref_out == old, "R8 mask restarted", ref_out, old);
    wait_toggle(n); chk(n == 10, "R8 fill-in from pulse", n, 10);
    wait_toggle(n); chk(n == H, "R7 mid", n, H);
    old = ref_out;
    vs_at(11);
    chk(ref_out != old, "R7 accepted at window end", ref_out, !old);
    wait_toggle(n); chk(n == H, "R7 mid after sync", n, H);
    old = ref_out;
    vs_at(10);
    chk(ref_out == old, "R7 masked pulse", ref_out, old);
    wait_toggle(n); chk(n == 10, "R7 no reload", n, 10);
  endtask

  task automatic t_same_cycle;
    int n; logic old;
    wait_toggle(n); chk(n == H, "R12 mid", n, H);
    old = ref_out;
    vs_at(H);
    chk(ref_out != old, "R12 single edge", ref_out, !old);
    old = ref_out;
    vs_at(5);
    chk(ref_out == old, "R12 no gap", ref_out, old);
    wait_toggle(n); chk(n == H - 5, "R12 mid from pulse", n, H - 5);
  endtask

  task automatic t_frame;
    int n;
    frame_en = 1'b1; field_sel = 1'b1; field_in = 1'b1;
    vs_at(12);
    chk(ref_out == 1'b1, "R11 match high", ref_out, 1);
    wait_toggle(n);
    field_in = 1'b0;
    vs_at(11);
    chk(ref_out == 1'b0, "R11 mismatch low", ref_out, 0);
    frame_en = 1'b0;
  endtask

  task automatic t_source;
    int n; logic old;
    force_free = 1'b1;
    wait_toggle(n);
    old = ref_out;
    vs_at(5);
    chk(ref_out == old, "R10 manual free-run", ref_out, old);
    wait_toggle(n); chk(n == H - 5, "R10 manual count", n, H - 5);
    auto_sel = 1'b1; force_free = 1'b0; noise_in = 1'b1;
    wait_toggle(n);
    old = ref_out;
    vs_at(5);
    chk(ref_out == old, "R10 noisy free-run", ref_out, old);
    wait_toggle(n); chk(n == H - 5, "R10 noisy count", n, H - 5);
    noise_in = 1'b0;
    old = ref_out;
    vs_at(1);
    chk(ref_out != old, "R10 auto locks", ref_out, !old);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_pb_sync();
    t_new_period();
    t_ext();
    t_rec_entry();
    t_locked();
    t_same_cycle();
    t_frame();
    t_source();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule